// File: doc/BRIEF.md
# Byte-wide arithmetic/logic unit with accumulator and status byte

This block performs one arithmetic or logic operation per clock on an 8-bit accumulator. The second operand comes either from a register input or from an immediate input, as chosen per operation. Each result is written back into the accumulator. Five condition flags are recomputed from the result and kept in a status byte that has fixed bit positions: sign, zero, nibble carry, parity and carry.

The accumulator and the status byte can each be loaded directly, and both can be loaded in the same cycle. A surrounding controller can therefore save the pair to a stack and restore it later. The outputs always show the current accumulator and status byte.

Top module: `byte_alu_core`

## Requirements
- R1: After reset (rst_n low at a clock edge) the accumulator is 0x00 and the status byte is 0x00.
- R2: Operation code 0 (add) sets acc to acc+operand modulo 256. Carry (status bit 0) is the carry out of bit 7. Nibble carry (status bit 4) is the carry out of bit 3.
- R3: Operation code 1 (subtract) sets acc to acc-operand modulo 256. Carry is set when the operand is unsigned-greater than acc. Nibble carry is set when the operand's low nibble is greater than acc's low nibble.
- R4: Operation code 2 (increment) adds 1 and sets nibble carry when the old low nibble was 0xF. Code 3 (decrement) subtracts 1 and sets nibble carry when the old low nibble was 0x0. Both leave carry unchanged.
- R5: Codes 4 (AND), 5 (OR) and 6 (XOR) combine acc with the operand bitwise and clear both carry and nibble carry.
- R6: Code 7 (complement) inverts every bit of acc and leaves all status bits unchanged.
- R7: Code 8 shifts acc left one place, filling with 0, and moves the old bit 7 into carry. Code 9 shifts right one place, filling with 0, and moves the old bit 0 into carry. Both clear nibble carry.
- R8: For codes 0 to 6, 8 and 9, sign (status bit 7) equals result bit 7, zero (status bit 6) is set when the result is 0x00, and parity (status bit 2) is set when the result holds an even number of ones.
- R9: The operand is the immediate input when opnd_sel is 1 and the register input when it is 0.
- R10: Status bits 5, 3 and 1 always read 0. A status load takes the five flag bits from psw_wdata in one cycle and discards the other bits.
- R11: acc_load and psw_load take effect in the same cycle when both are asserted. While op_valid is high, both loads are ignored.
- R12: With no strobe asserted, or with op_valid and a reserved code (10 to 15), the accumulator and the status byte keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Execute op_code this cycle |
| op_code | input | 4 | Operation select (see R2 to R7) |
| opnd_sel | input | 1 | 1: immediate operand, 0: register operand |
| reg_opnd | input | 8 | Register operand |
| imm_opnd | input | 8 | Immediate operand |
| acc_load | input | 1 | Load accumulator from acc_wdata |
| acc_wdata | input | 8 | Accumulator load value |
| psw_load | input | 1 | Load status byte from psw_wdata |
| psw_wdata | input | 8 | Status load value |
| acc_q | output | 8 | Current accumulator |
| psw_q | output | 8 | Current status byte |

## Verification
The bench builds the block with its default 8-bit data width, which is the only width that matches the fixed status byte layout. At this width, random accumulator and operand values reach every carry, borrow and nibble-carry boundary, including 0xFF+1, 0x00-1 and results that wrap to zero. Random strobe patterns also cover loads that coincide with operations and the reserved codes.

// File: rtl/alu_pkg.sv
// Package: operation codes and status byte bit positions shared by the ALU.
// Assumes an 8-bit status byte whose flag positions never move.
package alu_pkg;
    localparam int PSW_W   = 8;
    localparam int S_BIT   = 7;
    localparam int Z_BIT   = 6;
    localparam int AC_BIT  = 4;
    localparam int P_BIT   = 2;
    localparam int CY_BIT  = 0;
    localparam logic [PSW_W-1:0] PSW_MASK = 8'hD5;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_INC = 4'd2,
        OP_DEC = 4'd3,
        OP_AND = 4'd4,
        OP_OR  = 4'd5,
        OP_XOR = 4'd6,
        OP_NOT = 4'd7,
        OP_SHL = 4'd8,
        OP_SHR = 4'd9
    } alu_op_e;
endpackage

// File: rtl/alu_datapath.sv
// Module: alu_datapath
// Combinational result path. Produces the result, the raw carry and nibble
// carry, and tells the caller which status bits must be preserved.
// Assumes DATA_W >= 8 so that a low nibble exists.
module alu_datapath
    import alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [3:0]        op_code,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] res,
    output logic              cy_out,
    output logic              ac_out,
    output logic              keep_cy,
    output logic              keep_all,
    output logic              known
);
    localparam int NIB = 4;

    logic [DATA_W:0] wide;
    logic [NIB:0]    nib_sum;

    // Select the result and raw carries for the requested operation.
    always_comb begin
        res      = a;
        cy_out   = 1'b0;
        ac_out   = 1'b0;
        keep_cy  = 1'b0;
        keep_all = 1'b0;
        known    = 1'b1;
        wide     = '0;
        nib_sum  = '0;
        case (op_code)
            OP_ADD: begin
                wide    = {1'b0, a} + {1'b0, b};
                nib_sum = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]};
                res     = wide[DATA_W-1:0];
                cy_out  = wide[DATA_W];
                ac_out  = nib_sum[NIB];
            end
            OP_SUB: begin
                wide   = {1'b0, a} - {1'b0, b};
                res    = wide[DATA_W-1:0];
                cy_out = wide[DATA_W];
                ac_out = (b[NIB-1:0] > a[NIB-1:0]);
            end
            OP_INC: begin
                res     = a + 1'b1;
                ac_out  = &a[NIB-1:0];
                keep_cy = 1'b1;
            end
            OP_DEC: begin
                res     = a - 1'b1;
                ac_out  = ~|a[NIB-1:0];
                keep_cy = 1'b1;
            end
            OP_AND: res = a & b;
            OP_OR:  res = a | b;
            OP_XOR: res = a ^ b;
            OP_NOT: begin
                res      = ~a;
                keep_all = 1'b1;
            end
            OP_SHL: begin
                res    = {a[DATA_W-2:0], 1'b0};
                cy_out = a[DATA_W-1];
            end
            OP_SHR: begin
                res    = {1'b0, a[DATA_W-1:1]};
                cy_out = a[0];
            end
            default: known = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu_flag_gen.sv
// Module: alu_flag_gen
// Builds the next status byte from a result and its raw carries.
// Assumes the fixed bit layout of alu_pkg; unused bits are driven 0.
module alu_flag_gen
    import alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] res,
    input  logic              cy_in,
    input  logic              ac_in,
    input  logic              keep_cy,
    input  logic [PSW_W-1:0]  psw_old,
    output logic [PSW_W-1:0]  psw_next
);
    logic [DATA_W:0] par_chain;

    assign par_chain[0] = 1'b0;
    for (genvar i = 0; i < DATA_W; i++) begin : g_par
        assign par_chain[i+1] = par_chain[i] ^ res[i];
    end

    // Place each flag at its fixed position.
    always_comb begin
        psw_next         = '0;
        psw_next[S_BIT]  = res[DATA_W-1];
        psw_next[Z_BIT]  = (res == '0);
        psw_next[AC_BIT] = ac_in;
        psw_next[P_BIT]  = ~par_chain[DATA_W];
        psw_next[CY_BIT] = keep_cy ? psw_old[CY_BIT] : cy_in;
    end
endmodule

// File: rtl/byte_alu_core.sv
// Module: byte_alu_core
// Accumulator and status byte registers around the ALU datapath.
// An operation has priority over direct loads; the two loads are independent.
// Assumes a synchronous active-low reset.
module byte_alu_core
    import alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        op_code,
    input  logic              opnd_sel,
    input  logic [DATA_W-1:0] reg_opnd,
    input  logic [DATA_W-1:0] imm_opnd,
    input  logic              acc_load,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic              psw_load,
    input  logic [PSW_W-1:0]  psw_wdata,
    output logic [DATA_W-1:0] acc_q,
    output logic [PSW_W-1:0]  psw_q
);
    logic [DATA_W-1:0] operand;
    logic [DATA_W-1:0] res;
    logic              cy_raw;
    logic              ac_raw;
    logic              keep_cy;
    logic              keep_all;
    logic              known;
    logic [PSW_W-1:0]  psw_next;

    assign operand = opnd_sel ? imm_opnd : reg_opnd;

    alu_datapath #(.DATA_W(DATA_W)) u_dp (
        .op_code (op_code),
        .a       (acc_q),
        .b       (operand),
        .res     (res),
        .cy_out  (cy_raw),
        .ac_out  (ac_raw),
        .keep_cy (keep_cy),
        .keep_all(keep_all),
        .known   (known)
    );

    alu_flag_gen #(.DATA_W(DATA_W)) u_flags (
        .res     (res),
        .cy_in   (cy_raw),
        .ac_in   (ac_raw),
        .keep_cy (keep_cy),
        .psw_old (psw_q),
        .psw_next(psw_next)
    );

    // Update accumulator and status byte: reset, operation, then loads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            psw_q <= '0;
        end else if (op_valid) begin
            if (known) begin
                acc_q <= res;
                if (!keep_all) psw_q <= psw_next;
            end
        end else begin
            if (acc_load) acc_q <= acc_wdata;
            if (psw_load) psw_q <= psw_wdata & PSW_MASK;
        end
    end
endmodule

// File: rtl/alu_core_checker.sv
// Module: alu_core_checker
// Temporal checks on byte_alu_core ports, attached by bind below.
module alu_core_checker
    import alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [3:0]        op_code,
    input logic              psw_load,
    input logic [PSW_W-1:0]  psw_wdata,
    input logic [DATA_W-1:0] acc_q,
    input logic [PSW_W-1:0]  psw_q
);
    logic flag_op;
    assign flag_op = op_valid && (op_code <= 4'd9) && (op_code != 4'd7);

    assert_sign_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flag_op |=> psw_q[S_BIT] == acc_q[DATA_W-1]);
    assert_zero_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flag_op |=> psw_q[Z_BIT] == (acc_q == '0));
    assert_parity_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flag_op |=> psw_q[P_BIT] == ~(^acc_q));
    assert_incdec_keep_cy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && (op_code == 4'd2 || op_code == 4'd3)
        |=> psw_q[CY_BIT] == $past(psw_q[CY_BIT]));
    assert_logic_clear_cy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && (op_code >= 4'd4) && (op_code <= 4'd6)
        |=> !psw_q[CY_BIT] && !psw_q[AC_BIT]);
    assert_not_keeps_psw_R6: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_code == 4'd7 |=> $stable(psw_q));
    assert_psw_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid && psw_load |=> psw_q == ($past(psw_wdata) & PSW_MASK));
    assert_reserved_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_code >= 4'd10 |=> $stable(acc_q) && $stable(psw_q));
endmodule

bind byte_alu_core alu_core_checker #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_code  (op_code),
    .psw_load (psw_load),
    .psw_wdata(psw_wdata),
    .acc_q    (acc_q),
    .psw_q    (psw_q)
);

// File: tb/byte_alu_core_tb.sv
module byte_alu_core_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [3:0] op_code = '0;
    logic       opnd_sel = 1'b0;
    logic [7:0] reg_opnd = '0;
    logic [7:0] imm_opnd = '0;
    logic       acc_load = 1'b0;
    logic [7:0] acc_wdata = '0;
    logic       psw_load = 1'b0;
    logic [7:0] psw_wdata = '0;
    logic [7:0] acc_q;
    logic [7:0] psw_q;

    int checks = 0;
    int errors = 0;
    logic [7:0] e_acc = '0;
    logic [7:0] e_psw = '0;

    always #4 clk = ~clk;

    byte_alu_core u_dut (.*);

    // Reference model of one clock of the block.
    function automatic logic [15:0] model(input logic [7:0] a, input logic [7:0] p,
                                          input logic v, input logic [3:0] op,
                                          input logic [7:0] b, input logic al,
                                          input logic [7:0] ad, input logic pl,
                                          input logic [7:0] pd);
        logic [8:0] w;
        logic [7:0] r;
        logic cy, ac;
        logic [7:0] np;
        if (!v) begin
            return {al ? ad : a, pl ? (pd & 8'hD5) : p};
        end
        if (op > 4'd9) return {a, p};
        cy = 1'b0; ac = 1'b0; r = a;
        case (op)
            4'd0: begin w = a + b; r = w[7:0]; cy = w[8]; ac = (a[3:0] + b[3:0]) > 5'd15; end
            4'd1: begin r = a - b; cy = b > a; ac = b[3:0] > a[3:0]; end
            4'd2: begin r = a + 8'd1; cy = p[0]; ac = a[3:0] == 4'hF; end
            4'd3: begin r = a - 8'd1; cy = p[0]; ac = a[3:0] == 4'h0; end
            4'd4: r = a & b;
            4'd5: r = a | b;
            4'd6: r = a ^ b;
            4'd7: return {~a, p};
            4'd8: begin r = a << 1; cy = a[7]; end
            default: begin r = a >> 1; cy = a[0]; end
        endcase
        np = {r[7], r == 8'h00, 1'b0, ac, 1'b0, ~(^r), 1'b0, cy};
        return {r, np};
    endfunction

    function automatic string tag(input logic v, input logic [3:0] op);
        if (!v) return "R11/R12 load-or-idle";
        case (op)
            4'd0: return "R2 add R8";
            4'd1: return "R3 sub R8";
            4'd2, 4'd3: return "R4 incdec R8";
            4'd4, 4'd5, 4'd6: return "R5 logic R8";
            4'd7: return "R6 complement";
            4'd8, 4'd9: return "R7 shift R8";
            default: return "R12 reserved";
        endcase
    endfunction

    task automatic check(input string req);
        checks++;
        if (acc_q !== e_acc || psw_q !== e_psw) begin
            errors++;
            $display("FAIL %s: acc=%h psw=%h expected acc=%h psw=%h", req, acc_q, psw_q, e_acc, e_psw);
        end
    endtask

    // Drive one cycle of stimulus, then check the registered outcome.
    task automatic step(input logic v, input logic [3:0] op, input logic sel,
                        input logic [7:0] rb, input logic [7:0] ib,
                        input logic al, input logic [7:0] ad,
                        input logic pl, input logic [7:0] pd, input string req);
        logic [15:0] nx;
        op_valid = v; op_code = op; opnd_sel = sel; reg_opnd = rb; imm_opnd = ib;
        acc_load = al; acc_wdata = ad; psw_load = pl; psw_wdata = pd;
        nx = model(e_acc, e_psw, v, op, sel ? ib : rb, al, ad, pl, pd);
        @(negedge clk);
        op_valid = 0; acc_load = 0; psw_load = 0;
        e_acc = nx[15:8]; e_psw = nx[7:0];
        check(req);
    endtask

    task automatic setacc(input logic [7:0] v, input logic [7:0] p);
        step(0, 0, 0, 0, 0, 1, v, 1, p, "R11 joint load");
    endtask

    task automatic op(input logic [3:0] c, input logic [7:0] b);
        step(1, c, 0, b, ~b, 0, 0, 0, 0, tag(1, c));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        e_acc = 8'h00; e_psw = 8'h00;
        check("R1 reset");

        // R10: unused bits discarded
        step(0, 0, 0, 0, 0, 0, 0, 1, 8'hFF, "R10 status load");
        step(0, 0, 0, 0, 0, 0, 0, 1, 8'h2A, "R10 unused bits");
        // R2 corners
        setacc(8'hFF, 8'h00); op(4'd0, 8'h01);
        setacc(8'h0F, 8'h00); op(4'd0, 8'h01);
        // R3 borrow corners
        setacc(8'h00, 8'h00); op(4'd1, 8'h01);
        setacc(8'h10, 8'h00); op(4'd1, 8'h10);
        // R4: carry preserved
        setacc(8'hFF, 8'h01); op(4'd2, 8'h00);
        setacc(8'h00, 8'h00); op(4'd3, 8'h00);
        // R5, R6, R7
        setacc(8'hF0, 8'h11); op(4'd4, 8'h0F);
        setacc(8'h5A, 8'hD5); op(4'd7, 8'h00);
        setacc(8'h81, 8'h00); op(4'd8, 8'h00);
        setacc(8'h81, 8'h00); op(4'd9, 8'h00);
        // R9: immediate select
        setacc(8'h10, 8'h00);
        step(1, 4'd0, 1, 8'h01, 8'h22, 0, 0, 0, 0, "R9 immediate");
        step(1, 4'd0, 0, 8'h03, 8'h44, 0, 0, 0, 0, "R9 register");
        // R11: op has priority over loads
        step(1, 4'd2, 0, 0, 0, 1, 8'hAA, 1, 8'hFF, "R11 op priority");
        // R12: idle and reserved hold
        step(0, 0, 0, 8'hFF, 8'hFF, 0, 8'h55, 0, 8'hFF, "R12 idle");
        step(1, 4'd12, 0, 8'hFF, 8'hFF, 1, 8'h55, 1, 8'hFF, "R12 reserved");

        void'($urandom(32'h0C0FFEE5));
        for (int i = 0; i < 600; i++) begin
            logic v;
            logic [3:0] c;
            v = ($urandom % 5) != 0;
            c = ($urandom % 8 == 0) ? 4'($urandom % 16) : 4'($urandom % 10);
            step(v, c, 1'($urandom), 8'($urandom), 8'($urandom),
                 1'($urandom), 8'($urandom), 1'($urandom), 8'($urandom), tag(v, c));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #200000;
        errors++; checks++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule